// File: doc/BRIEF.md
# Register Bus Target with Wait Insertion

This block is a target on a single-master register bus with an 8-bit address, 16-bit write and read data, and four control lines: init, aval, re and we. It claims a window of four 16-bit register slots aligned at a base address set by a parameter. Inside that window it answers reads and writes with busy, ack and err, all decoded combinationally from the bus lines. Outside the window every response output stays at zero, so the responses of several targets can be OR-combined on the way back to the master.

The four slots are a control register, whose three low bits also drive the status outputs, a wait-count register, an attention trigger and a read-only identification word. A nonzero wait count holds busy high for that many cycles before an access completes. A write to the attention trigger shows the write data on the attention vector for exactly one cycle. An external init cycle aimed at the window clears all state when bit 0 of its pattern is set. Any control-line combination that the bus forbids raises a protocol-error flag and is not executed.

Top module: `regbus_target`

## Requirements
- R1: A read cycle (aval=1, re=1, we=0, init=0) whose address lies in the window completes with ack=1, err=0 and rdata equal to the addressed slot. Slot offsets within the window: 0 control, 1 wait count, 2 attention trigger, 3 identification.
- R2: A write cycle (aval=1, we=1, re=0, init=0) to the control slot stores all 16 bits at the completing clock edge, and a later read returns them. The control register is zero after reset.
- R3: When the wait count holds N, an access in the window keeps busy=1 for exactly N cycles and completes (busy=0, with ack and data) on the following cycle. N=0 completes in the first cycle. The write that changes the wait count is itself timed with the old count.
- R4: When no legal read or write addresses the window, busy, ack, err and rdata are all zero, and a write outside the window changes no register.
- R5: A read of the identification slot returns the parameter ID_VALUE with err=0. A write to it completes with ack=1 and err=1 and leaves the value unchanged.
- R6: A completed write to the attention trigger drives attn with the write data for exactly one cycle, after which attn returns to zero. A read of the trigger slot returns zero.
- R7: An external init (init=1, we=1, aval=0, re=0) addressed inside the window with pattern bit 0 set clears the control, wait-count and attention state at the next edge. An init with pattern bit 0 clear, an init with all other lines low, and an init addressed outside the window change nothing.
- R8: proto_err is 1 exactly when re or we is high with aval low and init low, when re and we are high together, when init and re are high together, or when init and aval are high together. Such a cycle neither reads nor writes nor acknowledges.
- R9: stat equals bits 2:0 of the control register at all times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 16 | Write data, also the init pattern |
| bus_init | input | 1 | Init cycle marker |
| bus_aval | input | 1 | Address valid |
| bus_re | input | 1 | Read enable |
| bus_we | input | 1 | Write enable |
| rsp_busy | output | 1 | Access not yet complete |
| rsp_ack | output | 1 | Address owned, access accepted |
| rsp_err | output | 1 | Access completed with an error |
| rsp_rdata | output | 16 | Read data, zero when not selected |
| attn | output | 16 | Attention vector, one-cycle pulses |
| stat | output | 3 | Status bits sampled by the master |
| proto_err | output | 1 | Illegal control-line combination |

## Verification
A corrupted wait counter shows at the ports as a busy window whose length differs from the programmed count. It appears on the very next access, because the bench counts busy cycles for every access it issues. A wrong register or attention value appears one cycle after the write that caused it: either as a wrong readback or as an attention pulse that is missing, stretched or carries the wrong pattern. A decode fault shows up in the same cycle as a protocol flag on a legal combination, or as a response outside the window. A leaked write shows up as a changed readback afterwards.

// File: rtl/regtgt_pkg.sv
package regtgt_pkg;
   localparam int OFS_W = 2;
   localparam logic [7:0] INT_INIT_LO = 8'hF8;

   typedef enum logic [OFS_W-1:0] {
      OFS_CTRL = 2'd0,
      OFS_WAIT = 2'd1,
      OFS_ATTN = 2'd2,
      OFS_ID   = 2'd3
   } reg_ofs_e;
endpackage

// File: rtl/regtgt_decode.sv
module regtgt_decode
   import regtgt_pkg::*;
#(
   parameter logic [7:0] BASE_ADDR = 8'h40
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [7:0]       addr,
   input  logic             init,
   input  logic             aval,
   input  logic             re,
   input  logic             we,
   output logic             rd_req,
   output logic             wr_req,
   output logic             ext_init,
   output logic             bad_ctl,
   output logic [OFS_W-1:0] ofs
);
   logic in_win;
   logic int_range;

   assign in_win    = (addr[7:OFS_W] == BASE_ADDR[7:OFS_W]);
   assign int_range = (addr >= INT_INIT_LO);
   assign ofs       = addr[OFS_W-1:0];

   assign bad_ctl = (!init && !aval && (re || we)) ||
                    (re && we) || (init && re) || (init && aval);

   assign rd_req   = aval && re && !we && !init && in_win;
   assign wr_req   = aval && we && !re && !init && in_win;
   assign ext_init = init && we && !aval && !re && in_win && !int_range;

   // R8: a forbidden combination never turns into a request
   p_illegal_idle_r8: assert property (@(posedge clk) disable iff (rst)
      bad_ctl |-> !(rd_req || wr_req || ext_init));
endmodule

// File: rtl/regtgt_waitseq.sv
module regtgt_waitseq #(
   parameter int WAIT_W = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req,
   input  logic [WAIT_W-1:0] wait_n,
   output logic              busy,
   output logic              done
);
   logic [WAIT_W-1:0] wcnt_q;

   assign busy = req && (wcnt_q < wait_n);
   assign done = req && !busy;

   always_ff @(posedge clk) begin
      if (rst)
         wcnt_q <= '0;
      else if (busy)
         wcnt_q <= wcnt_q + 1'b1;
      else
         wcnt_q <= '0;
   end

   // R3: completion happens exactly after the programmed number of waits
   p_wait_len_r3: assert property (@(posedge clk) disable iff (rst)
      done |-> (wcnt_q == wait_n));
   // R3: an idle bus leaves the wait counter at rest
   p_wait_rest_r3: assert property (@(posedge clk) disable iff (rst)
      !req |=> (wcnt_q == '0));
endmodule

// File: rtl/regtgt_bank.sv
module regtgt_bank
   import regtgt_pkg::*;
#(
   parameter int          WAIT_W   = 4,
   parameter bit          HAS_ID   = 1'b1,
   parameter logic [15:0] ID_VALUE = 16'hA5C3
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              rd_req,
   input  logic              wr_req,
   input  logic              done,
   input  logic              ext_init,
   input  logic [OFS_W-1:0]  ofs,
   input  logic [15:0]       wdata,
   output logic              ack,
   output logic              err,
   output logic [15:0]       rdata,
   output logic [15:0]       attn,
   output logic [2:0]        stat,
   output logic [WAIT_W-1:0] wait_n
);
   logic [15:0]       ctrl_q;
   logic [WAIT_W-1:0] wait_q;
   logic [15:0]       attn_q;
   logic              wr_done;
   logic              rd_done;
   logic              mapped;
   logic              ro_hit;
   logic [15:0]       id_word;
   logic [15:0]       slot_val;

   assign wr_done = done && wr_req;
   assign rd_done = done && rd_req;

   generate
      if (HAS_ID) begin : g_id
         assign id_word = ID_VALUE;
         assign mapped  = 1'b1;
         assign ro_hit  = (ofs == OFS_ID);
      end else begin : g_no_id
         assign id_word = '0;
         assign mapped  = (ofs != OFS_ID);
         assign ro_hit  = 1'b0;
      end
   endgenerate

   always_comb begin
      case (ofs)
         OFS_CTRL: slot_val = ctrl_q;
         OFS_WAIT: slot_val = {{(16-WAIT_W){1'b0}}, wait_q};
         OFS_ATTN: slot_val = '0;
         default:  slot_val = id_word;
      endcase
   end

   assign ack    = (rd_done || wr_done) && mapped;
   assign err    = wr_done && ro_hit;
   assign rdata  = (rd_req && mapped) ? slot_val : '0;
   assign attn   = attn_q;
   assign stat   = ctrl_q[2:0];
   assign wait_n = wait_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         ctrl_q <= '0;
         wait_q <= '0;
         attn_q <= '0;
      end else begin
         attn_q <= '0;
         if (ext_init && wdata[0]) begin
            ctrl_q <= '0;
            wait_q <= '0;
         end else if (wr_done) begin
            case (ofs)
               OFS_CTRL: ctrl_q <= wdata;
               OFS_WAIT: wait_q <= wdata[WAIT_W-1:0];
               OFS_ATTN: attn_q <= wdata;
               default:  ;
            endcase
         end
      end
   end

   // R6: attention bits fall one cycle after they rise unless rewritten
   p_attn_pulse_r6: assert property (@(posedge clk) disable iff (rst)
      (attn_q != '0) && !(wr_done && ofs == OFS_ATTN) |=> (attn_q == '0));
   // R7: clearing init empties the bank by the next cycle
   p_init_clear_r7: assert property (@(posedge clk) disable iff (rst)
      (ext_init && wdata[0]) |=> (ctrl_q == '0 && wait_q == '0 && attn_q == '0));
   // R5: an error is only ever reported on an acknowledged access
   p_err_with_ack_r5: assert property (@(posedge clk) disable iff (rst)
      err |-> ack);
endmodule

// File: rtl/regbus_target.sv
module regbus_target
   import regtgt_pkg::*;
#(
   parameter logic [7:0]  BASE_ADDR = 8'h40,
   parameter int          WAIT_W    = 4,
   parameter bit          HAS_ID    = 1'b1,
   parameter logic [15:0] ID_VALUE  = 16'hA5C3
) (
   input  logic        clk,
   input  logic        rst,
   input  logic [7:0]  bus_addr,
   input  logic [15:0] bus_wdata,
   input  logic        bus_init,
   input  logic        bus_aval,
   input  logic        bus_re,
   input  logic        bus_we,
   output logic        rsp_busy,
   output logic        rsp_ack,
   output logic        rsp_err,
   output logic [15:0] rsp_rdata,
   output logic [15:0] attn,
   output logic [2:0]  stat,
   output logic        proto_err
);
   localparam logic [7:0] WIN_TOP = BASE_ADDR + 8'((1 << OFS_W) - 1);

   generate
      if (WAIT_W < 1 || WAIT_W > 16) begin : g_bad_wait
         $error("WAIT_W must lie in 1..16");
      end
      if (BASE_ADDR[OFS_W-1:0] != '0) begin : g_bad_align
         $error("BASE_ADDR must be aligned to the window size");
      end
      if (WIN_TOP >= INT_INIT_LO) begin : g_bad_range
         $error("window must not overlap the internal init range");
      end
   endgenerate

   logic             rd_req;
   logic             wr_req;
   logic             ext_init;
   logic [OFS_W-1:0] ofs;
   logic             done;
   logic [WAIT_W-1:0] wait_n;

   regtgt_decode #(.BASE_ADDR(BASE_ADDR)) u_dec (
      .clk      (clk),
      .rst      (rst),
      .addr     (bus_addr),
      .init     (bus_init),
      .aval     (bus_aval),
      .re       (bus_re),
      .we       (bus_we),
      .rd_req   (rd_req),
      .wr_req   (wr_req),
      .ext_init (ext_init),
      .bad_ctl  (proto_err),
      .ofs      (ofs)
   );

   regtgt_waitseq #(.WAIT_W(WAIT_W)) u_seq (
      .clk    (clk),
      .rst    (rst),
      .req    (rd_req || wr_req),
      .wait_n (wait_n),
      .busy   (rsp_busy),
      .done   (done)
   );

   regtgt_bank #(
      .WAIT_W   (WAIT_W),
      .HAS_ID   (HAS_ID),
      .ID_VALUE (ID_VALUE)
   ) u_bank (
      .clk      (clk),
      .rst      (rst),
      .rd_req   (rd_req),
      .wr_req   (wr_req),
      .done     (done),
      .ext_init (ext_init),
      .ofs      (ofs),
      .wdata    (bus_wdata),
      .ack      (rsp_ack),
      .err      (rsp_err),
      .rdata    (rsp_rdata),
      .attn     (attn),
      .stat     (stat),
      .wait_n   (wait_n)
   );

   // R4: no selected access means a silent response
   p_quiet_outside_r4: assert property (@(posedge clk) disable iff (rst)
      !(rd_req || wr_req) |-> (!rsp_busy && !rsp_ack && !rsp_err && rsp_rdata == '0));
   // R3: busy and ack never overlap
   p_busy_no_ack_r3: assert property (@(posedge clk) disable iff (rst)
      rsp_busy |-> !rsp_ack);
endmodule

// File: tb/sim_regbus_target.sv
module sim_regbus_target;
   localparam int CLK_P = 10;
   localparam logic [7:0] BASE = 8'h40;
   localparam logic [15:0] IDV = 16'hA5C3;

   typedef struct {
      logic        ack;
      logic        err;
      logic [15:0] rdata;
      bit          is_rd;
      int          waits;
      string       req;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [7:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic        bus_init = 1'b0;
   logic        bus_aval = 1'b0;
   logic        bus_re = 1'b0;
   logic        bus_we = 1'b0;
   logic        rsp_busy, rsp_ack, rsp_err, proto_err;
   logic [15:0] rsp_rdata, attn;
   logic [2:0]  stat;

   int   n_tests = 0;
   int   n_fail  = 0;
   bit   live = 1'b0;
   bit   mon_done = 1'b0;
   bit   finished = 1'b0;
   int   bcnt = 0;
   exp_t exp_q[$];

   always #(CLK_P/2) clk = ~clk;

   regbus_target #(.BASE_ADDR(BASE), .ID_VALUE(IDV)) u0 (
      .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_init(bus_init), .bus_aval(bus_aval), .bus_re(bus_re), .bus_we(bus_we),
      .rsp_busy(rsp_busy), .rsp_ack(rsp_ack), .rsp_err(rsp_err),
      .rsp_rdata(rsp_rdata), .attn(attn), .stat(stat), .proto_err(proto_err)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic report();
      if (!finished) begin
         finished = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   endtask

   // monitor: pops the expected item when the access completes
   always @(negedge clk) begin
      #2;
      if (live && !mon_done) begin
         if (rsp_busy) bcnt++;
         else begin
            exp_t e;
            e = exp_q.pop_front();
            chk(rsp_ack == e.ack, {e.req, " ack"}, int'(rsp_ack), int'(e.ack));
            chk(rsp_err == e.err, {e.req, " err"}, int'(rsp_err), int'(e.err));
            chk(bcnt == e.waits, {e.req, " wait cycles"}, bcnt, e.waits);
            if (e.is_rd)
               chk(rsp_rdata == e.rdata, {e.req, " rdata"}, int'(rsp_rdata), int'(e.rdata));
            bcnt = 0;
            mon_done = 1'b1;
         end
      end
   end

   // driver: pushes the expectation and runs one bus access
   task automatic access(input logic [7:0] a, input bit wr, input logic [15:0] d,
                         input logic eack, input logic eerr, input logic [15:0] erd,
                         input int ew, input string req);
      exp_t e;
      e.ack = eack; e.err = eerr; e.rdata = erd; e.is_rd = !wr; e.waits = ew; e.req = req;
      exp_q.push_back(e);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_aval = 1'b1; bus_re = !wr; bus_we = wr;
      live = 1'b1;
      wait (mon_done);
      @(posedge clk);
      @(negedge clk);
      bus_aval = 1'b0; bus_re = 1'b0; bus_we = 1'b0; bus_wdata = '0;
      live = 1'b0;
      mon_done = 1'b0;
   endtask

   task automatic drive_ctl(input logic [3:0] c, input logic [7:0] a, input logic [15:0] d);
      @(negedge clk);
      {bus_init, bus_aval, bus_re, bus_we} = c;
      bus_addr = a; bus_wdata = d;
   endtask

   task automatic idle_ctl();
      @(negedge clk);
      {bus_init, bus_aval, bus_re, bus_we} = 4'b0000;
      bus_wdata = '0;
   endtask

   initial begin
      #(CLK_P * 100000);
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      #1;
      chk(rsp_busy == 1'b0 && rsp_ack == 1'b0 && rsp_rdata == '0, "R4 reset response",
          int'({rsp_busy, rsp_ack}), 0);
      chk(attn == '0, "R6 reset attn", int'(attn), 0);
      chk(stat == '0, "R9 reset stat", int'(stat), 0);

      // R1/R2 basic read and write
      access(BASE + 0, 0, 0, 1, 0, 16'h0000, 0, "R2 ctrl reset value");
      access(BASE + 0, 1, 16'h1235, 1, 0, 0, 0, "R2 ctrl write");
      access(BASE + 0, 0, 0, 1, 0, 16'h1235, 0, "R2 ctrl readback");
      #1 chk(stat == 3'b101, "R9 stat follows ctrl", int'(stat), 5);
      access(BASE + 1, 0, 0, 1, 0, 16'h0000, 0, "R1 wait slot read");

      // R3 wait insertion
      access(BASE + 1, 1, 16'h0003, 1, 0, 0, 0, "R3 program wait 3");
      access(BASE + 0, 0, 0, 1, 0, 16'h1235, 3, "R3 read with waits");
      access(BASE + 0, 1, 16'hBEEF, 1, 0, 0, 3, "R3 write with waits");
      access(BASE + 1, 0, 0, 1, 0, 16'h0003, 3, "R1 wait slot readback");
      access(BASE + 1, 1, 16'h0000, 1, 0, 0, 3, "R3 clear wait uses old count");
      access(BASE + 0, 0, 0, 1, 0, 16'hBEEF, 0, "R3 zero wait read");
      #1 chk(stat == 3'b111, "R9 stat after rewrite", int'(stat), 7);

      // R5 identification slot
      access(BASE + 3, 0, 0, 1, 0, IDV, 0, "R5 id read");
      access(BASE + 3, 1, 16'h0000, 1, 1, 0, 0, "R5 id write error");
      access(BASE + 3, 0, 0, 1, 0, IDV, 0, "R5 id unchanged");

      // R4 outside the window
      access(8'h80, 0, 0, 0, 0, 16'h0000, 0, "R4 foreign read");
      access(8'h44, 1, 16'h0001, 0, 0, 0, 0, "R4 foreign write");
      access(BASE + 0, 0, 0, 1, 0, 16'hBEEF, 0, "R4 ctrl untouched");

      // R6 attention pulse
      access(BASE + 2, 1, 16'h8001, 1, 0, 0, 0, "R6 attn write");
      #1 chk(attn == 16'h8001, "R6 attn pulse value", int'(attn), 16'h8001);
      @(negedge clk);
      #1 chk(attn == 16'h0000, "R6 attn one cycle", int'(attn), 0);
      access(BASE + 2, 0, 0, 1, 0, 16'h0000, 0, "R6 trigger reads zero");

      // R8 illegal combinations: init aval re we
      begin
         logic [3:0] bad [7];
         bad = '{4'b0010, 4'b0001, 4'b0011, 4'b0111, 4'b1010, 4'b1100, 4'b1110};
         for (int i = 0; i < 7; i++) begin
            drive_ctl(bad[i], BASE + 0, 16'h0000);
            #1;
            chk(proto_err == 1'b1, "R8 illegal flagged", int'(proto_err), 1);
            chk(rsp_ack == 1'b0 && rsp_busy == 1'b0, "R8 illegal not answered",
                int'({rsp_ack, rsp_busy}), 0);
         end
         drive_ctl(4'b1000, BASE, 16'h0000);
         #1 chk(proto_err == 1'b0, "R8 internal init legal", int'(proto_err), 0);
         drive_ctl(4'b0110, BASE, 16'h0000);
         #1 chk(proto_err == 1'b0, "R8 read legal", int'(proto_err), 0);
         idle_ctl();
      end
      access(BASE + 0, 0, 0, 1, 0, 16'hBEEF, 0, "R8 illegal did not write");

      // R7 init handling
      access(BASE + 1, 1, 16'h0002, 1, 0, 0, 0, "R7 set wait before init");
      drive_ctl(4'b1000, BASE, 16'h0001);
      idle_ctl();
      access(BASE + 0, 0, 0, 1, 0, 16'hBEEF, 2, "R7 internal init ignored");
      drive_ctl(4'b1001, BASE, 16'hFFFE);
      idle_ctl();
      access(BASE + 0, 0, 0, 1, 0, 16'hBEEF, 2, "R7 pattern bit0 clear ignored");
      drive_ctl(4'b1001, 8'hF8, 16'h0001);
      idle_ctl();
      access(BASE + 0, 0, 0, 1, 0, 16'hBEEF, 2, "R7 foreign init ignored");
      drive_ctl(4'b1001, BASE + 2, 16'h0001);
      idle_ctl();
      #1 chk(stat == 3'b000, "R7 init clears status", int'(stat), 0);
      access(BASE + 0, 0, 0, 1, 0, 16'h0000, 0, "R7 init cleared ctrl");
      access(BASE + 1, 0, 0, 1, 0, 16'h0000, 0, "R7 init cleared wait");
      chk(attn == '0, "R7 attn clear", int'(attn), 0);

      repeat (2) @(negedge clk);
      report();
   end
endmodule